// File: doc/BRIEF.md
# Three-Channel PWM Timer with Input Capture

This block is a 16-bit up-counter. It advances once per clock on which the `tick` enable is high. It returns to zero after it reaches a limit value (TOP), and the operating mode picks that limit. Three compare channels watch the count. Each channel keeps a staged compare value and an active copy. On a match a channel raises a sticky flag and either toggles its pin or shapes a single-slope PWM waveform. A capture unit copies the count into a capture register when a chosen edge arrives on one of two input lines. A four-sample spike filter can be placed in front of that edge detector.

Software-side setup goes through one write port: an enable, a 3-bit address and 16 bits of data. Addresses: 0 holds the mode in bits [2:0] and the per-channel output inversion in bits [5:3] (bit 3 for channel A, 4 for B, 5 for C). Addresses 1, 2 and 3 are the staged compare values for A, B and C. Address 4 is the capture register. Address 5 holds the interrupt enables in bits [4:0]. Writing 1s to address 6 clears flags. Address 7 configures capture: bit 0 selects the alternate input, bit 1 turns the filter on, and bit 2 picks the rising edge (0 picks falling).

The flag vector carries the compare flags of A, B and C in bits 0 to 2, the wrap flag in bit 3 and the capture flag in bit 4. `irq` is high while any enabled flag is set.

Top module: `pwm_capture_timer`

## Requirements
- R1: After reset the count, flags, outputs and capture register are zero. On a clock with `tick` high the count goes up by one, or goes to 0 if it equals TOP. With `tick` low the count holds.
- R2: TOP per mode code: 0 gives 0xFFFF; 1 and 6 give active compare A; 2 and 7 give the capture register; 3 gives 0x00FF; 4 gives 0x01FF; 5 gives 0x03FF. Modes 3 to 7 are PWM modes, so the count period is TOP+1 ticks.
- R3: A tick on which the count equals a channel's active compare value sets that channel's flag (bit 0 A, 1 B, 2 C). A tick that wraps the count from TOP to 0 sets flag bit 3.
- R4: Writing to address 6 clears every flag whose data bit is 1. A set event in the same cycle wins. `irq` is high exactly when a flag and its enable bit at address 5 are both 1.
- R5: In PWM modes an active compare value takes its staged value only on the wrapping tick, so a mid-period write leaves the current period unchanged. In modes 0 to 2 the active value follows the staged value one clock after the write.
- R6: In PWM modes a non-inverted output is high exactly while the count is below the active compare value. It therefore stays high for min(compare, TOP+1) ticks of each period. Setting the channel's inversion bit gives the complement.
- R7: In mode 6 the channel A output is held low. In mode 7 channel A produces PWM normally.
- R8: In modes 0 to 2 a channel output toggles on each tick that matches its compare value.
- R9: With the filter off, a selected edge on the selected input captures the count present during the first clock after the one in which the input changed. It also sets flag bit 4. The other edge polarity captures nothing.
- R10: With the filter on, a new level is accepted only after four consecutive samples agree. The capture then takes the count from the fourth clock after the change, and shorter pulses are ignored.
- R11: In modes 2 and 7, where the capture register is TOP, input edges neither change the capture register nor set flag bit 4. A write to address 4 still loads it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| cap_pin | input | 1 | Primary capture input |
| cap_alt | input | 1 | Alternate capture input |
| pwm_out | output | 3 | Channel outputs A, B, C in bits 0..2 |
| irq | output | 1 | Interrupt request |
| flags | output | 5 | Sticky event flags |
| count | output | 16 | Current counter value |
| cap_val | output | 16 | Capture register |

## Verification
The bench measures period and high time for each fixed TOP. Its cases include compare values of zero, of exactly TOP and above TOP, inverted outputs, and a TOP taken from channel A or from the capture register. A design with an off-by-one comparator or wrap would show a period of TOP or TOP+2, or a high time one tick off. A compare write in the middle of a PWM period must not change that period. An unbuffered design would show a mixed high time. The capture latency is checked exactly with the filter off and on, and so are spike rejection, the alternate source and the falling polarity. A filter of the wrong length, or a capture that runs while the capture register is TOP, gives a wrong captured count.

// File: rtl/pct_pkg.sv
`timescale 1ns/1ps
package pct_pkg;

    localparam int CNT_W  = 16;
    localparam int NCH    = 3;
    localparam int NFLG   = NCH + 2;
    localparam int FLT_N  = 4;

    localparam logic [2:0] A_CTRL  = 3'd0;
    localparam logic [2:0] A_CMP0  = 3'd1;
    localparam logic [2:0] A_CAPR  = 3'd4;
    localparam logic [2:0] A_IEN   = 3'd5;
    localparam logic [2:0] A_FCLR  = 3'd6;
    localparam logic [2:0] A_CCFG  = 3'd7;

    localparam int F_WRAP = NCH;
    localparam int F_CAP  = NCH + 1;

    typedef enum logic [2:0] {
        MD_NORMAL   = 3'd0,
        MD_CLR_A    = 3'd1,
        MD_CLR_CAP  = 3'd2,
        MD_FAST8    = 3'd3,
        MD_FAST9    = 3'd4,
        MD_FAST10   = 3'd5,
        MD_FAST_A   = 3'd6,
        MD_FAST_CAP = 3'd7
    } mode_e;

    typedef struct packed {
        logic rise;
        logic filt_en;
        logic src_alt;
    } capcfg_t;

    function automatic logic is_pwm(mode_e m);
        return m >= MD_FAST8;
    endfunction

    function automatic logic cap_is_top(mode_e m);
        return (m == MD_CLR_CAP) || (m == MD_FAST_CAP);
    endfunction

    function automatic logic [CNT_W-1:0] pick_top(mode_e m, logic [CNT_W-1:0] a,
                                                  logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] t;
        case (m)
            MD_CLR_A, MD_FAST_A:     t = a;
            MD_CLR_CAP, MD_FAST_CAP: t = c;
            MD_FAST8:                t = CNT_W'(16'h00FF);
            MD_FAST9:                t = CNT_W'(16'h01FF);
            MD_FAST10:               t = CNT_W'(16'h03FF);
            default:                 t = '1;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pct_counter.sv
`timescale 1ns/1ps
module pct_counter #(
    parameter int W = pct_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] top,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output logic         wrap
);
    logic at_top;

    always_comb begin
        at_top  = (cnt == top);
        wrap    = tick && at_top;
        if (!tick)
            cnt_nxt = cnt;
        else if (at_top)
            cnt_nxt = '0;
        else
            cnt_nxt = cnt + W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else
            cnt <= cnt_nxt;
    end
endmodule

// File: rtl/pct_cmp_chan.sv
`timescale 1ns/1ps
module pct_cmp_chan #(
    parameter int W = pct_pkg::CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] cnt_nxt,
    input  logic         pwm_mode,
    input  logic         silent,
    input  logic         invert,
    input  logic [W-1:0] staged,
    output logic [W-1:0] act,
    output logic         match,
    output logic         pin
);
    logic [W-1:0] act_nxt;
    logic         load;

    always_comb begin
        load    = !pwm_mode || wrap;
        act_nxt = load ? staged : act;
        match   = tick && (cnt == act);
    end

    always_ff @(posedge clk) begin
        if (rst)
            act <= '0;
        else
            act <= act_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst || silent)
            pin <= 1'b0;
        else if (pwm_mode) begin
            if (tick)
                pin <= invert ^ (cnt_nxt < act_nxt);
        end else if (match)
            pin <= ~pin;
    end
endmodule

// File: rtl/pct_capture.sv
`timescale 1ns/1ps
module pct_capture #(
    parameter int FLT = pct_pkg::FLT_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cap_pin,
    input  logic             cap_alt,
    input  pct_pkg::capcfg_t cfg,
    input  logic             block,
    output logic             evt
);
    logic [FLT-1:0] hist;
    logic           lvl, lvl_nxt, src;

    always_comb begin
        src = cfg.src_alt ? cap_alt : cap_pin;
        if (!cfg.filt_en)
            lvl_nxt = hist[0];
        else if (&hist)
            lvl_nxt = 1'b1;
        else if (~|hist)
            lvl_nxt = 1'b0;
        else
            lvl_nxt = lvl;
        evt = (lvl_nxt != lvl) && (lvl_nxt == cfg.rise) && !block;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist <= '0;
            lvl  <= 1'b0;
        end else begin
            hist <= {hist[FLT-2:0], src};
            lvl  <= lvl_nxt;
        end
    end
endmodule

// File: rtl/pwm_capture_timer.sv
`timescale 1ns/1ps
module pwm_capture_timer
    import pct_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             cap_pin,
    input  logic             cap_alt,
    output logic [NCH-1:0]   pwm_out,
    output logic             irq,
    output logic [NFLG-1:0]  flags,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] cap_val
);
    mode_e                      mode_q;
    logic [NCH-1:0]             inv_q;
    logic [NCH-1:0][CNT_W-1:0]  staged_q;
    logic [NCH-1:0][CNT_W-1:0]  cmp_act;
    logic [NCH-1:0]             match;
    logic [NFLG-1:0]            ien_q, set_v, clr_v;
    capcfg_t                    ccfg_q;
    logic [CNT_W-1:0]           icr_q, top_val, cnt_nxt;
    logic                       wrap, cap_evt, icr_top, a_top;

    always_comb begin
        top_val = pick_top(mode_q, cmp_act[0], icr_q);
        icr_top = cap_is_top(mode_q);
        a_top   = (mode_q == MD_FAST_A);
        set_v   = {cap_evt, wrap, match};
        clr_v   = (wr_en && wr_addr == A_FCLR) ? wr_data[NFLG-1:0] : '0;
        irq     = |(flags & ien_q);
        cap_val = icr_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= MD_NORMAL;
            inv_q    <= '0;
            ien_q    <= '0;
            ccfg_q   <= '0;
            staged_q <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                A_CTRL: begin
                    mode_q <= mode_e'(wr_data[2:0]);
                    inv_q  <= wr_data[3 +: NCH];
                end
                A_IEN:  ien_q  <= wr_data[NFLG-1:0];
                A_CCFG: ccfg_q <= capcfg_t'(wr_data[2:0]);
                default: begin
                    for (int i = 0; i < NCH; i++)
                        if (wr_addr == A_CMP0 + 3'(i))
                            staged_q[i] <= wr_data;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            icr_q <= '0;
        else if (wr_en && wr_addr == A_CAPR)
            icr_q <= wr_data;
        else if (cap_evt)
            icr_q <= count;
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags <= '0;
        else
            flags <= (flags & ~clr_v) | set_v;
    end

    pct_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .top(top_val),
        .cnt(count), .cnt_nxt(cnt_nxt), .wrap(wrap)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pct_cmp_chan #(.W(CNT_W)) u_ch (
            .clk(clk), .rst(rst), .tick(tick), .wrap(wrap),
            .cnt(count), .cnt_nxt(cnt_nxt),
            .pwm_mode(is_pwm(mode_q)),
            .silent((g == 0) && a_top),
            .invert(inv_q[g]),
            .staged(staged_q[g]),
            .act(cmp_act[g]),
            .match(match[g]),
            .pin(pwm_out[g])
        );
    end

    pct_capture #(.FLT(FLT_N)) u_cap (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .cap_alt(cap_alt),
        .cfg(ccfg_q), .block(icr_top), .evt(cap_evt)
    );
endmodule

// File: rtl/pct_checker.sv
`timescale 1ns/1ps
module pct_checker
    import pct_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic                     tick,
    input logic                     wr_en,
    input logic [2:0]               wr_addr,
    input logic [CNT_W-1:0]         wr_data,
    input logic [CNT_W-1:0]         count,
    input logic [CNT_W-1:0]         top_val,
    input logic                     wrap,
    input logic [NFLG-1:0]          flags,
    input logic [NCH-1:0]           pwm_out,
    input logic [2:0]               mode,
    input logic [NCH-1:0][CNT_W-1:0] cmp_act,
    input logic [CNT_W-1:0]         cap_val
);
    logic pwm_m, icr_m, clr_wrap;
    assign pwm_m    = mode >= 3'd3;
    assign icr_m    = (mode == 3'd2) || (mode == 3'd7);
    assign clr_wrap = wr_en && (wr_addr == A_FCLR) && wr_data[F_WRAP];

    AST_WRAP_TO_BOTTOM: assert property (@(posedge clk) disable iff (rst)
        tick && count == top_val |=> count == '0); // R1
    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count)); // R1
    AST_WRAP_FLAG: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flags[F_WRAP]); // R3
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        clr_wrap && !wrap |=> !flags[F_WRAP]); // R4
    AST_BUF_HOLD: assert property (@(posedge clk) disable iff (rst)
        pwm_m && !wrap |=> $stable(cmp_act)); // R5
    AST_A_SILENT: assert property (@(posedge clk) disable iff (rst)
        mode == 3'd6 |=> !pwm_out[0]); // R7
    AST_ICR_LOCKED: assert property (@(posedge clk) disable iff (rst)
        icr_m && !(wr_en && wr_addr == A_CAPR) |=> $stable(cap_val)); // R11
endmodule

bind pwm_capture_timer pct_checker u_chk (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .top_val(top_val), .wrap(wrap),
    .flags(flags), .pwm_out(pwm_out), .mode(mode_q), .cmp_act(cmp_act),
    .cap_val(cap_val)
);

// File: tb/tb_pwm_capture_timer.sv
`timescale 1ns/1ps
module tb_pwm_capture_timer;
    logic        clk = 1'b0, rst = 1'b1, tick = 1'b1, wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        cap_pin = 1'b0, cap_alt = 1'b0;
    logic [2:0]  pwm_out;
    logic        irq;
    logic [4:0]  flags;
    logic [15:0] count, cap_val;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    pwm_capture_timer dut (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cap_pin(cap_pin), .cap_alt(cap_alt),
        .pwm_out(pwm_out), .irq(irq), .flags(flags), .count(count), .cap_val(cap_val)
    );

    always #2 clk = ~clk;

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; tick = 1'b1;
        cap_pin = 1'b0; cap_alt = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input int d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = 16'(d);
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic wait_bottom();
        @(negedge clk);
        while (count != 16'd0) @(negedge clk);
    endtask

    task automatic settle();
        wait_bottom(); @(negedge clk); wait_bottom();
    endtask

    task automatic measure(input int top, output int h0, output int h1, output int h2,
                           output int endc);
        h0 = 0; h1 = 0; h2 = 0;
        for (int i = 0; i <= top; i++) begin
            h0 += int'(pwm_out[0]); h1 += int'(pwm_out[1]); h2 += int'(pwm_out[2]);
            @(negedge clk);
        end
        endc = int'(count);
    endtask

    function automatic int exp_hi(int ocr, int top, bit inv);
        int h = (ocr > top + 1) ? top + 1 : ocr;
        return inv ? top + 1 - h : h;
    endfunction

    function automatic int top_of(int m);
        return (m == 3) ? 255 : (m == 4) ? 511 : 1023;
    endfunction

    task automatic run_fixed(int m, int a, int b, int c, int inv);
        int h0, h1, h2, e, t;
        t = top_of(m);
        do_reset();
        wr(3'd1, a); wr(3'd2, b); wr(3'd3, c); wr(3'd0, (inv << 3) | m);
        settle();
        measure(t, h0, h1, h2, e);
        chk("R2 R6 period back to bottom", e, 0);
        chk("R6 duty A", h0, exp_hi(a, t, inv[0]));
        chk("R6 duty B", h1, exp_hi(b, t, inv[1]));
        chk("R6 duty C", h2, exp_hi(c, t, inv[2]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int h0, h1, h2, e, c0, n;
        logic s;
        void'($urandom(32'd20240611));

        // R1 reset state
        do_reset();
        chk("R1 reset count", int'(count), 0);
        chk("R1 reset flags", int'(flags), 0);
        chk("R1 reset pwm", int'(pwm_out), 0);
        chk("R1 reset irq", int'(irq), 0);
        chk("R1 reset capture", int'(cap_val), 0);

        // R1 hold without tick
        repeat (4) @(negedge clk);
        tick = 1'b0; c0 = int'(count);
        repeat (5) @(negedge clk);
        chk("R1 hold while tick low", int'(count), c0);
        tick = 1'b1; @(negedge clk);
        chk("R1 advance on tick", int'(count), c0 + 1);

        // directed fixed-TOP corners
        run_fixed(3, 0, 128, 255, 0);
        run_fixed(4, 511, 600, 1, 0);
        run_fixed(5, 300, 0, 100, 3'b100);
        // random fixed-TOP mixes
        for (int k = 0; k < 6; k++) begin
            int m = 3 + int'($urandom_range(2));
            int t = top_of(m);
            run_fixed(m, int'($urandom_range(t + 8)), int'($urandom_range(t + 8)),
                      int'($urandom_range(t + 8)), int'($urandom_range(7)));
        end

        // R5 mid-period write does not disturb the running period
        do_reset();
        wr(3'd2, 64); wr(3'd0, 3);
        settle();
        h1 = 0;
        for (int i = 0; i < 256; i++) begin
            h1 += int'(pwm_out[1]);
            if (i == 100) begin wr_en = 1'b1; wr_addr = 3'd2; wr_data = 16'd192; end
            if (i == 101) wr_en = 1'b0;
            @(negedge clk);
        end
        chk("R5 old duty kept in period of write", h1, 64);
        measure(255, h0, h1, h2, e);
        chk("R5 new duty after wrap", h1, 192);

        // R2 R7 channel A as TOP
        do_reset();
        wr(3'd1, 149); wr(3'd2, 50); wr(3'd0, 6);
        settle();
        measure(149, h0, h1, h2, e);
        chk("R2 period from compare A", e, 0);
        chk("R7 channel A silent", h0, 0);
        chk("R6 duty B with A as TOP", h1, 50);

        // R2 R7 R11 capture register as TOP
        do_reset();
        wr(3'd4, 99); wr(3'd1, 25); wr(3'd0, 7);
        settle();
        measure(99, h0, h1, h2, e);
        chk("R2 period from capture register", e, 0);
        chk("R7 channel A active when capture is TOP", h0, 25);
        wr(3'd7, 3'b100); wr(3'd6, 5'h1F);
        cap_pin = 1'b1;
        repeat (6) @(negedge clk);
        chk("R11 capture register locked", int'(cap_val), 99);
        chk("R11 no capture flag", int'(flags[4]), 0);

        // R8 clear-on-match with A
        do_reset();
        wr(3'd1, 49); wr(3'd0, 1);
        wait_bottom();
        s = pwm_out[0]; n = 0;
        do begin @(negedge clk); n++; end while (count != 16'd0);
        chk("R2 clear-on-match period", n, 50);
        chk("R8 A toggles once per period", int'(pwm_out[0] != s), 1);

        // R3 R4 flags and irq
        do_reset();
        wr(3'd2, 30); wr(3'd0, 3); wr(3'd5, 5'b00010);
        settle();
        wr(3'd6, 5'h1F);
        while (count != 16'd30) @(negedge clk);
        chk("R3 B flag clear before match", int'(flags[1]), 0);
        chk("R4 irq low before match", int'(irq), 0);
        @(negedge clk);
        chk("R3 B flag set on match", int'(flags[1]), 1);
        chk("R4 irq on enabled flag", int'(irq), 1);
        wr(3'd6, 5'b00010);
        chk("R4 write-one clears B flag", int'(flags[1]), 0);
        chk("R4 irq drops", int'(irq), 0);
        wait_bottom();
        chk("R3 wrap flag set", int'(flags[3]), 1);
        chk("R4 disabled flag gives no irq", int'(irq), 0);

        // R5 immediate load outside PWM
        do_reset();
        wr(3'd3, 40); wr(3'd6, 5'h1F);
        while (count != 16'd40) @(negedge clk);
        chk("R5 C flag before match", int'(flags[2]), 0);
        @(negedge clk);
        chk("R5 C flag after immediate load", int'(flags[2]), 1);

        // R9 unfiltered rising capture
        do_reset();
        wr(3'd7, 3'b100); repeat (3) @(negedge clk); wr(3'd6, 5'h1F);
        c0 = int'(count); cap_pin = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 unfiltered capture value", int'(cap_val), c0 + 1);
        chk("R9 capture flag", int'(flags[4]), 1);
        c0 = int'(cap_val);
        wr(3'd6, 5'h1F); cap_pin = 1'b0;
        repeat (4) @(negedge clk);
        chk("R9 falling edge ignored", int'(cap_val), c0);

        // R10 filtered capture
        wr(3'd7, 3'b110); repeat (6) @(negedge clk); wr(3'd6, 5'h1F);
        c0 = int'(count); cap_pin = 1'b1;
        repeat (7) @(negedge clk);
        chk("R10 filtered capture value", int'(cap_val), c0 + 4);
        cap_pin = 1'b0; repeat (8) @(negedge clk);
        wr(3'd6, 5'h1F); c0 = int'(cap_val);
        cap_pin = 1'b1; repeat (2) @(negedge clk); cap_pin = 1'b0;
        repeat (8) @(negedge clk);
        chk("R10 spike rejected value", int'(cap_val), c0);
        chk("R10 spike rejected flag", int'(flags[4]), 0);

        // R9 alternate source, falling edge
        cap_alt = 1'b1;
        wr(3'd7, 3'b001); repeat (6) @(negedge clk); wr(3'd6, 5'h1F);
        c0 = int'(count); cap_alt = 1'b0;
        repeat (3) @(negedge clk);
        chk("R9 alternate falling capture", int'(cap_val), c0 + 1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule